// File: doc/BRIEF.md
# Streaming Signed Argmax Unit

This block watches a stream of signed integers and reports which element was the largest and where it sat in the stream. Elements arrive one per accepted cycle on a valid/ready input. A start marker opens a search and a last marker closes it. While a search is open, the block keeps a running maximum and the zero-based position of the element that set it. The cycle after the closing element is accepted, a one-cycle done strobe marks the result as final. The index and the maximum then stay fixed until the next start marker.

A later element replaces the running maximum only if it is strictly larger in signed order, so among equal values the earliest one keeps the index. The running maximum begins each search at the most negative representable value, and the running index begins at -1. A search that closes without any element therefore reports -1. So does a search whose elements all equal the most negative value. To close a search with no elements, raise the start and last markers together while valid is low.

Top module: `stream_argmax`

## Requirements
- R1: While reset is asserted, inReady is 0, resDone is 0, resIdx is -1 (all ones) and resMax is the most negative value (only the sign bit set). inReady rises at the first clock edge after reset is released.
- R2: Once inReady is high it stays high. An element is accepted on every cycle where inValid and inReady are both high, with no stall cycles.
- R3: Elements are compared as two's-complement signed values, so a negative element never displaces a larger positive or less negative maximum.
- R4: A later element equal to the running maximum does not change resIdx or resMax. Ties keep the earliest position.
- R5: The element index counts accepted elements from 0 within the search. Cycles with inValid low inside a search do not advance the count.
- R6: resDone is high for exactly one cycle, in the cycle after the element carrying inLast is accepted. In that cycle resIdx and resMax hold the final result, and both stay unchanged until the next start.
- R7: A cycle with inStart and inLast high and inValid low closes an empty search. In the next cycle resDone is high, resIdx is -1 and resMax is the most negative value.
- R8: If every element of a search equals the most negative value, the search reports resIdx -1.
- R9: inStart clears the running state. An element accepted with inStart becomes index 0. A start inside an open search abandons the old search without a done strobe.
- R10: Outside an open search, elements without inStart and a lone inLast are ignored. They cause no done strobe and do not change resIdx or resMax.
- R11: A new search may start in the cycle right after the previous one's last element. A run of single-element searches gives a done strobe on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Element present on inData |
| inReady | output | 1 | Block can accept an element |
| inData | input | DATA_W | Signed element value |
| inStart | input | 1 | Opens a new search |
| inLast | input | 1 | Closes the current search |
| resDone | output | 1 | One-cycle strobe: result is final |
| resIdx | output | IDX_W | Signed index of the maximum, -1 if none |
| resMax | output | DATA_W | Signed maximum value |

## Verification
The bench uses the default widths, 32-bit data and a 32-bit index. At these widths the exact most negative sentinel, the all-ones -1 index and the sign boundary at both extremes of the data range can be driven directly. It also mixes directed searches with random ones whose values are drawn from a narrow range, so ties, gaps, empty searches and restarts are frequent. Overflow of the element counter lies out of reach at this index width within the bench's run length.

// File: rtl/argmax_pkg.sv
package argmax_pkg;

  typedef struct packed {
    logic clearRun;
    logic loadElem;
    logic firstElem;
  } dpCtl_t;

  typedef enum logic {
    ST_IDLE,
    ST_ACTIVE
  } ctlState_t;

endpackage

// File: rtl/argmax_ctrl.sv
module argmax_ctrl
  import argmax_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inStart,
  input  logic   inLast,
  output logic   inReady,
  output dpCtl_t dpCtl,
  output logic   resDone
);

  ctlState_t state, nextState;
  logic      readyQ;
  logic      doneQ;
  logic      accept;
  logic      emptyOpen;
  logic      endEvt;

  assign accept    = inValid & readyQ;
  assign emptyOpen = inStart & ~inValid & readyQ;

  always_comb begin
    dpCtl     = '0;
    nextState = state;
    endEvt    = 1'b0;
    if (inStart && accept) begin
      dpCtl.loadElem  = 1'b1;
      dpCtl.firstElem = 1'b1;
      nextState       = inLast ? ST_IDLE : ST_ACTIVE;
      endEvt          = inLast;
    end else if (emptyOpen) begin
      dpCtl.clearRun = 1'b1;
      nextState      = inLast ? ST_IDLE : ST_ACTIVE;
      endEvt         = inLast;
    end else if (accept && state == ST_ACTIVE) begin
      dpCtl.loadElem = 1'b1;
      if (inLast) begin
        nextState = ST_IDLE;
        endEvt    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      readyQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      state  <= nextState;
      readyQ <= 1'b1;
      doneQ  <= endEvt;
    end
  end

  assign inReady = readyQ;
  assign resDone = doneQ;

  // R2: ready never drops once raised
  a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rstN)
    readyQ |=> readyQ);

  // R10: idle without a start never yields done
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !inStart) |=> !doneQ);

  // R9: only one datapath action per cycle
  a_r9_single_action: assert property (@(posedge clk) disable iff (!rstN)
    !(dpCtl.clearRun && dpCtl.loadElem));

endmodule

// File: rtl/argmax_datapath.sv
module argmax_datapath
  import argmax_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   dpCtl,
  input  logic signed [DATA_W-1:0] inData,
  output logic signed [DATA_W-1:0] runMax,
  output logic signed [IDX_W-1:0]  runIdx
);

  localparam logic signed [DATA_W-1:0] MIN_VAL  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [IDX_W-1:0]  NONE_IDX = '1;

  logic        [IDX_W-1:0]  count;
  logic        [IDX_W-1:0]  elemPos;
  logic signed [DATA_W-1:0] baseline;
  logic                     wins;

  always_comb begin
    elemPos  = dpCtl.firstElem ? '0 : count;
    baseline = dpCtl.firstElem ? MIN_VAL : runMax;
    wins     = inData > baseline;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      runMax <= MIN_VAL;
      runIdx <= NONE_IDX;
    end else if (dpCtl.clearRun) begin
      count  <= '0;
      runMax <= MIN_VAL;
      runIdx <= NONE_IDX;
    end else if (dpCtl.loadElem) begin
      count <= elemPos + 1'b1;
      if (wins) begin
        runMax <= inData;
        runIdx <= $signed(elemPos);
      end else if (dpCtl.firstElem) begin
        runMax <= MIN_VAL;
        runIdx <= NONE_IDX;
      end
    end
  end

  // R4: an equal later element leaves the index alone
  a_r4_tie_keeps_index: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.loadElem && !dpCtl.firstElem && inData == runMax) |=> $stable(runIdx));

  // R3: within a search the maximum never decreases
  a_r3_max_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.loadElem && !dpCtl.firstElem) |=> (runMax >= $past(runMax)));

  // R5: a valid index always points at an already counted element
  a_r5_index_below_count: assert property (@(posedge clk) disable iff (!rstN)
    (runIdx != NONE_IDX) |-> ($unsigned(runIdx) < count));

  // R9: a first element above the sentinel becomes index 0
  a_r9_first_is_zero: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.loadElem && dpCtl.firstElem && inData != MIN_VAL) |=> (runIdx == 0));

  // R8: the sentinel value alone never claims an index
  a_r8_min_no_index: assert property (@(posedge clk) disable iff (!rstN)
    (runMax == MIN_VAL) |-> (runIdx == NONE_IDX));

endmodule

// File: rtl/stream_argmax.sv
module stream_argmax
  import argmax_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inStart,
  input  logic              inLast,
  output logic              resDone,
  output logic [IDX_W-1:0]  resIdx,
  output logic [DATA_W-1:0] resMax
);

  localparam logic [IDX_W-1:0] NONE_IDX = '1;

  dpCtl_t                   dpCtl;
  logic signed [DATA_W-1:0] runMax;
  logic signed [IDX_W-1:0]  runIdx;

  argmax_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inStart (inStart),
    .inLast  (inLast),
    .inReady (inReady),
    .dpCtl   (dpCtl),
    .resDone (resDone)
  );

  argmax_datapath #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .dpCtl  (dpCtl),
    .inData ($signed(inData)),
    .runMax (runMax),
    .runIdx (runIdx)
  );

  assign resIdx = runIdx;
  assign resMax = runMax;

  // R6: done only follows a cycle that carried the last marker
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> $past(inLast));

  // R7: an empty search reports no index
  a_r7_empty_result: assert property (@(posedge clk) disable iff (!rstN)
    (inStart && inLast && !inValid && inReady) |=> (resDone && resIdx == NONE_IDX));

  // R6: without a start the result holds after done
  a_r6_result_holds: assert property (@(posedge clk) disable iff (!rstN)
    (resDone && !inStart && !inValid) |=> ($stable(resIdx) && $stable(resMax)));

endmodule

// File: tb/tb_stream_argmax.sv
`timescale 1ns/100ps
module tb_stream_argmax;

  localparam longint MIN_VAL = -64'sd2147483648;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        inStart = 1'b0;
  logic        inLast = 1'b0;
  logic        resDone;
  logic [31:0] resIdx;
  logic [31:0] resMax;

  int    errors = 0;
  int    checks = 0;
  bit    finished = 1'b0;
  string curTag = "R1";

  // reference model state
  bit     mReady = 1'b0;
  bit     mActive = 1'b0;
  bit     mDone = 1'b0;
  longint mMax = MIN_VAL;
  longint mIdx = -1;
  longint mCnt = 0;

  always #2.5 clk = ~clk;

  stream_argmax dut (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .inData  (inData),
    .inStart (inStart),
    .inLast  (inLast),
    .resDone (resDone),
    .resIdx  (resIdx),
    .resMax  (resMax)
  );

  function automatic void modelTake(longint d);
    if (d > mMax) begin
      mMax = d;
      mIdx = mCnt;
    end
    mCnt++;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReady = 0; mActive = 0; mDone = 0;
      mMax = MIN_VAL; mIdx = -1; mCnt = 0;
    end else begin
      bit     acc;
      bit     rdy;
      longint d;
      rdy = mReady;
      acc = inValid && rdy;
      d = longint'($signed(inData));
      mDone = 0;
      if (inStart && acc) begin
        mCnt = 0; mMax = MIN_VAL; mIdx = -1;
        modelTake(d);
        mActive = !inLast; mDone = inLast;
      end else if (inStart && !inValid && rdy) begin
        mCnt = 0; mMax = MIN_VAL; mIdx = -1;
        mActive = !inLast; mDone = inLast;
      end else if (acc && mActive) begin
        modelTake(d);
        if (inLast) begin mActive = 0; mDone = 1; end
      end
      mReady = 1;
    end
  end

  task automatic check(string tag, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compareModel();
    check({curTag, " done"}, resDone == mDone, resDone, mDone);
    check({curTag, " ready R2"}, inReady == mReady, inReady, mReady);
    check({curTag, " index"}, longint'($signed(resIdx)) == mIdx, $signed(resIdx), mIdx);
    check({curTag, " max"}, longint'($signed(resMax)) == mMax, $signed(resMax), mMax);
  endtask

  // drive at a falling edge, clock once, compare at the next falling edge
  task automatic step(bit v, longint d, bit s, bit l);
    inValid = v; inData = 32'(d); inStart = s; inLast = l;
    @(posedge clk);
    @(negedge clk);
    compareModel();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic expectResult(string tag, longint idx, longint mx);
    check({tag, " done"}, resDone == 1'b1, resDone, 1);
    check({tag, " index"}, longint'($signed(resIdx)) == idx, $signed(resIdx), idx);
    check({tag, " max"}, longint'($signed(resMax)) == mx, $signed(resMax), mx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    check("R1 ready in reset", inReady == 1'b0, inReady, 0);
    check("R1 done in reset", resDone == 1'b0, resDone, 0);
    check("R1 index in reset", $signed(resIdx) == -1, $signed(resIdx), -1);
    check("R1 max in reset", longint'($signed(resMax)) == MIN_VAL, $signed(resMax), MIN_VAL);
    rstN = 1'b1;
    step(0, 0, 0, 0);
    check("R1 ready after reset", inReady == 1'b1, inReady, 1);

    // R3 R4 R6: ties and signs
    curTag = "R4";
    step(1, 3, 1, 0); step(1, -5, 0, 0); step(1, 7, 0, 0);
    step(1, 7, 0, 0); step(1, 2, 0, 1);
    expectResult("R4 tie keeps first", 2, 7);
    curTag = "R6";
    step(0, 0, 0, 0);
    check("R6 done one cycle", resDone == 1'b0, resDone, 0);
    idle(3);
    check("R6 index held", $signed(resIdx) == 2, $signed(resIdx), 2);
    check("R6 max held", $signed(resMax) == 7, $signed(resMax), 7);

    curTag = "R3";
    step(1, -10, 1, 0); step(1, -3, 0, 0); step(1, -20, 0, 1);
    expectResult("R3 negatives", 1, -3);
    step(1, 2147483647, 1, 0); step(1, MIN_VAL, 0, 1);
    expectResult("R3 extremes", 0, 2147483647);

    curTag = "R7";
    step(0, 0, 1, 1);
    expectResult("R7 empty", -1, MIN_VAL);

    curTag = "R8";
    step(1, MIN_VAL, 1, 0); step(1, MIN_VAL, 0, 0); step(1, MIN_VAL, 0, 1);
    expectResult("R8 all minimum", -1, MIN_VAL);

    curTag = "R5";
    step(1, 5, 1, 0); step(0, 99, 0, 0); step(1, 9, 0, 0);
    step(0, 99, 0, 0); step(1, 1, 0, 1);
    expectResult("R5 gaps not counted", 1, 9);

    curTag = "R10";
    step(1, 100, 0, 0);
    check("R10 stray no done", resDone == 1'b0, resDone, 0);
    step(0, 0, 0, 1);
    check("R10 lone last no done", resDone == 1'b0, resDone, 0);
    step(1, 200, 0, 1);
    check("R10 stray last no done", resDone == 1'b0, resDone, 0);
    check("R10 index unchanged", $signed(resIdx) == 1, $signed(resIdx), 1);
    check("R10 max unchanged", $signed(resMax) == 9, $signed(resMax), 9);

    curTag = "R9";
    step(1, 50, 1, 0); step(1, 60, 0, 0);
    step(1, 4, 1, 0);
    check("R9 restart no done", resDone == 1'b0, resDone, 0);
    step(1, 8, 0, 1);
    expectResult("R9 restart", 1, 8);
    step(0, 0, 1, 0); step(1, -7, 0, 0); step(1, -9, 0, 1);
    expectResult("R9 start then data", 0, -7);

    curTag = "R11";
    step(1, 11, 1, 1);
    expectResult("R11 first single", 0, 11);
    step(1, 12, 1, 1);
    expectResult("R11 second single", 0, 12);
    step(1, -1, 1, 1);
    expectResult("R11 third single", 0, -1);
    step(0, 0, 0, 0);
    check("R11 done ends", resDone == 1'b0, resDone, 0);

    // random searches against the model
    curTag = "R2 random";
    for (int f = 0; f < 300; f++) begin
      int len;
      len = $urandom_range(0, 8);
      if (len == 0) begin
        step(0, 0, 1, 1);
      end else begin
        for (int e = 0; e < len; e++) begin
          longint v;
          case ($urandom_range(0, 9))
            0: v = MIN_VAL;
            1: v = 2147483647;
            default: v = longint'($urandom_range(0, 6)) - 3;
          endcase
          if ($urandom_range(0, 3) == 0) step(0, 77, 0, 0);
          step(1, v, e == 0, e == len - 1);
        end
      end
      if ($urandom_range(0, 2) == 0) step($urandom_range(0, 1), 55, 0, $urandom_range(0, 1));
    end
    idle(2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule